// File: doc/BRIEF.md
# Byte-Stream Network Register Block

This block is a small network interface that a processor drives entirely through a 32-bit memory-mapped register window. Frame payload moves through fixed single-byte data ports, one byte per bus access. Counters tell software how many bytes remain to be read, or how many it has promised to write. On the device side, received frames arrive on a byte stream that marks the first and last byte of each frame. Transmit bytes leave on a byte stream with a valid/ready handshake. Each direction holds exactly one frame in a local buffer. A single level interrupt reports receive arrival, transmit completion and a software-injected test event.

The receive side is a three-state machine. RX_IDLE waits for a byte flagged as first and moves to RX_FILL. If that byte is also last, it moves straight to RX_HOLD. RX_FILL stores bytes until the last-flagged byte arrives and then moves to RX_HOLD. RX_HOLD holds the frame while software drains it, and returns to RX_IDLE once the remaining count reaches zero. The transmit side is also three states. TX_IDLE moves to TX_LOAD when software writes a nonzero count. TX_LOAD moves to TX_SEND on the data write that fills the count. TX_SEND returns to TX_IDLE when the stream accepts the final byte.

The window spans 64 bytes and the bus uses a single-cycle access with combinational read data. Read side effects happen in the cycle of the access: draining the receive port and clearing the test bit. The buffer depth `MAX_FRAME` is a parameter; in the full-size configuration it equals the architectural limit of 65536 bytes.

Top module: `bsnic_top`

## Requirements
- R1: Reads at offset 0x00 return bits 31:0 and reads at 0x04 return bits 63:32 of the 64-bit identifier `DEV_ID`, which holds eight ASCII characters with the first in bits 7:0 and each later one 8 bits higher. Offset 0x18 returns the parameter `INFO_WORD`. Every other offset reads zero, and writes to read-only or unused offsets change nothing.
- R2: The busy word at 0x08 reads 1 while the receive machine is in RX_FILL or the transmit machine is in TX_SEND, and reads 0 otherwise.
- R3: In RX_IDLE, a stream byte with the first marker starts a frame, and bytes without it are taken and discarded. When the byte with the last marker is taken, the receive count at 0x0c is loaded with the number of bytes stored and interrupt-control bit 1 is set on the same edge.
- R4: Each read of the receive data port at 0x1c returns the next stored byte in bits 7:0 with bits 31:8 zero, and lowers the receive count by one. When the count is zero, the read returns zero and changes nothing.
- R5: While interrupt-control bit 1 is set, `rx_ready` is low and no offered frame is taken.
- R6: A received frame longer than `MAX_FRAME` bytes loads the count with `MAX_FRAME`. The first `MAX_FRAME` bytes are kept and the rest are dropped.
- R7: In TX_IDLE, a nonzero write to 0x10 sets the transmit count, clamped to `MAX_FRAME`. Writing zero, or writing while a frame is pending, is ignored. Bytes written to 0x20 (bits 7:0) are buffered in order, and `tx_valid` stays low until the full count has been written.
- R8: In TX_SEND the stream presents the buffered bytes in write order, with `tx_last` high only on the final byte. `tx_data` and `tx_last` hold while `tx_valid` is high and `tx_ready` is low.
- R9: On the edge where the final byte is accepted, the transmit count becomes 0 and interrupt-control bit 0 is set.
- R10: Writing 0x14 with bit 0 or bit 1 at 1 clears that bit. A write with those bits at 0 leaves them unchanged.
- R11: Writing 0x14 with bit 31 at 1 sets the test bit. Writing the whole register as zero clears it. A read of 0x14 returns the test bit and clears it after the read.
- R12: `irq` is high exactly when any of interrupt-control bits 0, 1 or 31 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Bus access strobe, one access per cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 6 | Byte offset into the window |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, valid in the access cycle |
| rx_valid | input | 1 | Receive stream byte valid |
| rx_ready | output | 1 | Receive stream ready |
| rx_data | input | 8 | Receive stream byte |
| rx_first | input | 1 | Marks the first byte of a frame |
| rx_last | input | 1 | Marks the last byte of a frame |
| tx_valid | output | 1 | Transmit stream byte valid |
| tx_ready | input | 1 | Transmit stream ready |
| tx_data | output | 8 | Transmit stream byte |
| tx_last | output | 1 | Marks the final transmit byte |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that the host issues at most one access per cycle and uses the word offsets of the map. They also assume that the transmit stream sink may stall for any number of cycles but never takes a byte without `tx_ready`. The stimulus meets these assumptions: every bus access comes from one task that drives a single cycle and then idles. `tx_ready` is randomised per cycle from a fixed seed, and receive frames are offered with legal first/last markers. A deliberately blocked frame is offered only while receive-done is set. Frames longer than the buffer are used only to exercise truncation.

// File: rtl/bsnic_pkg.sv
`timescale 1ns/1ps
package bsnic_pkg;

    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_FILL = 2'd1,
        RX_HOLD = 2'd2
    } rx_state_e;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_LOAD = 2'd1,
        TX_SEND = 2'd2
    } tx_state_e;

    // byte offsets of the register window
    localparam int OFS_ID_LO  = 'h00;
    localparam int OFS_ID_HI  = 'h04;
    localparam int OFS_BUSY   = 'h08;
    localparam int OFS_RXCNT  = 'h0c;
    localparam int OFS_TXCNT  = 'h10;
    localparam int OFS_INTCTL = 'h14;
    localparam int OFS_INFO   = 'h18;
    localparam int OFS_RXDAT  = 'h1c;
    localparam int OFS_TXDAT  = 'h20;

    localparam int IRQ_TX_BIT   = 0;
    localparam int IRQ_RX_BIT   = 1;
    localparam int IRQ_TEST_BIT = 31;

endpackage

// File: rtl/bsnic_rx.sv
`timescale 1ns/1ps
module bsnic_rx
    import bsnic_pkg::*;
#(
    parameter int MAX_FRAME = 64,
    parameter int CNT_W     = $clog2(MAX_FRAME + 1),
    parameter int IDX_W     = (MAX_FRAME > 1) ? $clog2(MAX_FRAME) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s_valid,
    output logic             s_ready,
    input  logic [7:0]       s_data,
    input  logic             s_first,
    input  logic             s_last,
    input  logic             block,
    input  logic             pop,
    output logic [7:0]       rd_byte,
    output logic [CNT_W-1:0] left_cnt,
    output logic             done,
    output logic             filling
);

    rx_state_e        state_q, state_d;
    logic [CNT_W-1:0] wr_cnt_q;
    logic [CNT_W-1:0] left_q;
    logic [IDX_W-1:0] rd_idx_q;
    logic [7:0]       mem [MAX_FRAME];

    logic take, start, store;
    logic [IDX_W-1:0] wr_addr;

    // next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE: if (take && s_first) state_d = s_last ? RX_HOLD : RX_FILL;
            RX_FILL: if (take && s_last)  state_d = RX_HOLD;
            RX_HOLD: if (left_q == '0)    state_d = RX_IDLE;
            default:                      state_d = RX_IDLE;
        endcase
    end

    // output process
    always_comb begin
        s_ready = ((state_q == RX_IDLE) && !block) || (state_q == RX_FILL);
        filling = (state_q == RX_FILL);
        take    = s_valid && s_ready;
        start   = (state_q == RX_IDLE) && take && s_first;
        store   = start || ((state_q == RX_FILL) && take && (wr_cnt_q < CNT_W'(MAX_FRAME)));
        done    = take && s_last && (start || (state_q == RX_FILL));
        wr_addr = start ? '0 : wr_cnt_q[IDX_W-1:0];
        rd_byte = (left_q != '0) ? mem[rd_idx_q] : 8'h00;
        left_cnt = left_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (store) mem[wr_addr] <= s_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_cnt_q <= '0;
            left_q   <= '0;
            rd_idx_q <= '0;
        end else begin
            if (start)      wr_cnt_q <= CNT_W'(1);
            else if (store) wr_cnt_q <= wr_cnt_q + 1'b1;

            if (done) begin
                if (start)      left_q <= CNT_W'(1);
                else if (store) left_q <= wr_cnt_q + 1'b1;
                else            left_q <= wr_cnt_q;
                rd_idx_q <= '0;
            end else if (pop && (left_q != '0)) begin
                left_q   <= left_q - 1'b1;
                rd_idx_q <= rd_idx_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/bsnic_tx.sv
`timescale 1ns/1ps
module bsnic_tx
    import bsnic_pkg::*;
#(
    parameter int MAX_FRAME = 64,
    parameter int CNT_W     = $clog2(MAX_FRAME + 1),
    parameter int IDX_W     = (MAX_FRAME > 1) ? $clog2(MAX_FRAME) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_we,
    input  logic [31:0]      cnt_wdata,
    input  logic             dat_we,
    input  logic [7:0]       dat_byte,
    output logic             m_valid,
    input  logic             m_ready,
    output logic [7:0]       m_data,
    output logic             m_last,
    output logic [CNT_W-1:0] cnt_out,
    output logic             sending,
    output logic             done
);

    tx_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] idx_q;
    logic [7:0]       mem [MAX_FRAME];

    logic             arm, at_end;
    logic [CNT_W-1:0] clamped;

    always_comb begin
        clamped = (cnt_wdata > 32'(MAX_FRAME)) ? CNT_W'(MAX_FRAME) : CNT_W'(cnt_wdata);
        at_end  = (CNT_W'(idx_q) + 1'b1) == cnt_q;
        arm     = (state_q == TX_IDLE) && cnt_we && (cnt_wdata != 32'd0);
    end

    // next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: if (arm)               state_d = TX_LOAD;
            TX_LOAD: if (dat_we && at_end)  state_d = TX_SEND;
            TX_SEND: if (m_ready && at_end) state_d = TX_IDLE;
            default:                        state_d = TX_IDLE;
        endcase
    end

    // output process
    always_comb begin
        m_valid = (state_q == TX_SEND);
        m_data  = mem[idx_q];
        m_last  = (state_q == TX_SEND) && at_end;
        sending = (state_q == TX_SEND);
        done    = (state_q == TX_SEND) && m_ready && at_end;
        cnt_out = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if ((state_q == TX_LOAD) && dat_we) mem[idx_q] <= dat_byte;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            idx_q <= '0;
        end else begin
            if (arm) begin
                cnt_q <= clamped;
                idx_q <= '0;
            end else if ((state_q == TX_LOAD) && dat_we) begin
                idx_q <= at_end ? '0 : idx_q + 1'b1;
            end else if (done) begin
                cnt_q <= '0;
                idx_q <= '0;
            end else if ((state_q == TX_SEND) && m_ready) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/bsnic_irq.sv
`timescale 1ns/1ps
module bsnic_irq
    import bsnic_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        set_tx,
    input  logic        set_rx,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    input  logic        rd_en,
    output logic [31:0] ctl_word,
    output logic        irq
);

    logic tx_q, rx_q, test_q;
    logic tx_d, rx_d, test_d;

    always_comb begin
        tx_d   = tx_q;
        rx_d   = rx_q;
        test_d = test_q;
        if (wr_en) begin
            if (wdata == 32'd0) begin
                test_d = 1'b0;
            end else begin
                if (wdata[IRQ_TX_BIT])   tx_d   = 1'b0;
                if (wdata[IRQ_RX_BIT])   rx_d   = 1'b0;
                if (wdata[IRQ_TEST_BIT]) test_d = 1'b1;
            end
        end
        if (rd_en)  test_d = 1'b0;
        if (set_tx) tx_d   = 1'b1;
        if (set_rx) rx_d   = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q   <= 1'b0;
            rx_q   <= 1'b0;
            test_q <= 1'b0;
        end else begin
            tx_q   <= tx_d;
            rx_q   <= rx_d;
            test_q <= test_d;
        end
    end

    always_comb begin
        ctl_word               = '0;
        ctl_word[IRQ_TX_BIT]   = tx_q;
        ctl_word[IRQ_RX_BIT]   = rx_q;
        ctl_word[IRQ_TEST_BIT] = test_q;
        irq                    = tx_q | rx_q | test_q;
    end

endmodule

// File: rtl/bsnic_top.sv
`timescale 1ns/1ps
module bsnic_top
    import bsnic_pkg::*;
#(
    parameter logic [63:0] DEV_ID       = 64'h3143_494E_4554_5942,
    parameter logic [31:0] INFO_WORD    = 32'h0000_0007,
    parameter int          MAX_FRAME    = 64,
    parameter int          WINDOW_BYTES = 64
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            host_sel,
    input  logic                            host_we,
    input  logic [$clog2(WINDOW_BYTES)-1:0] host_addr,
    input  logic [31:0]                     host_wdata,
    output logic [31:0]                     host_rdata,
    input  logic                            rx_valid,
    output logic                            rx_ready,
    input  logic [7:0]                      rx_data,
    input  logic                            rx_first,
    input  logic                            rx_last,
    output logic                            tx_valid,
    input  logic                            tx_ready,
    output logic [7:0]                      tx_data,
    output logic                            tx_last,
    output logic                            irq
);

    localparam int CNT_W = $clog2(MAX_FRAME + 1);
    localparam int IDX_W = (MAX_FRAME > 1) ? $clog2(MAX_FRAME) : 1;

    logic             wr, rd;
    int               ofs;
    logic [7:0]       rx_byte;
    logic [CNT_W-1:0] rx_left, tx_cnt;
    logic             rx_done, rx_filling, tx_done, tx_sending, busy;
    logic [31:0]      ctl_word;

    always_comb begin
        wr   = host_sel && host_we;
        rd   = host_sel && !host_we;
        ofs  = int'(host_addr);
        busy = rx_filling || tx_sending;
    end

    bsnic_rx #(.MAX_FRAME(MAX_FRAME), .CNT_W(CNT_W), .IDX_W(IDX_W)) rx_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .s_valid  (rx_valid),
        .s_ready  (rx_ready),
        .s_data   (rx_data),
        .s_first  (rx_first),
        .s_last   (rx_last),
        .block    (ctl_word[IRQ_RX_BIT]),
        .pop      (rd && (ofs == OFS_RXDAT)),
        .rd_byte  (rx_byte),
        .left_cnt (rx_left),
        .done     (rx_done),
        .filling  (rx_filling)
    );

    bsnic_tx #(.MAX_FRAME(MAX_FRAME), .CNT_W(CNT_W), .IDX_W(IDX_W)) tx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_we    (wr && (ofs == OFS_TXCNT)),
        .cnt_wdata (host_wdata),
        .dat_we    (wr && (ofs == OFS_TXDAT)),
        .dat_byte  (host_wdata[7:0]),
        .m_valid   (tx_valid),
        .m_ready   (tx_ready),
        .m_data    (tx_data),
        .m_last    (tx_last),
        .cnt_out   (tx_cnt),
        .sending   (tx_sending),
        .done      (tx_done)
    );

    bsnic_irq irq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_tx   (tx_done),
        .set_rx   (rx_done),
        .wr_en    (wr && (ofs == OFS_INTCTL)),
        .wdata    (host_wdata),
        .rd_en    (rd && (ofs == OFS_INTCTL)),
        .ctl_word (ctl_word),
        .irq      (irq)
    );

    // read mux
    always_comb begin
        host_rdata = '0;
        unique case (ofs)
            OFS_ID_LO:  host_rdata = DEV_ID[31:0];
            OFS_ID_HI:  host_rdata = DEV_ID[63:32];
            OFS_BUSY:   host_rdata = {31'd0, busy};
            OFS_RXCNT:  host_rdata = 32'(rx_left);
            OFS_TXCNT:  host_rdata = 32'(tx_cnt);
            OFS_INTCTL: host_rdata = ctl_word;
            OFS_INFO:   host_rdata = INFO_WORD;
            OFS_RXDAT:  host_rdata = {24'd0, rx_byte};
            default:    host_rdata = '0;
        endcase
    end

endmodule

// File: rtl/bsnic_chk.sv
`timescale 1ns/1ps
module bsnic_chk #(
    parameter int AW = 6,
    parameter int CW = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          host_sel,
    input logic          host_we,
    input logic [AW-1:0] host_addr,
    input logic [31:0]   host_wdata,
    input logic          rx_ready,
    input logic          tx_valid,
    input logic          tx_ready,
    input logic [7:0]    tx_data,
    input logic          tx_last,
    input logic [31:0]   ctl_word,
    input logic [CW-1:0] rx_left,
    input logic [CW-1:0] tx_cnt,
    input logic          busy
);

    assert_rx_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_word[1] |-> !rx_ready);

    assert_tx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    assert_tx_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && tx_last) |=> ((tx_cnt == '0) && ctl_word[0]));

    assert_rx_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_sel && !host_we && (int'(host_addr) == 'h1c) && (rx_left != '0))
        |=> (rx_left == CW'($past(rx_left) - 1'b1)));

    assert_test_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (host_sel && host_we && (int'(host_addr) == 'h14) && host_wdata[31]) |=> ctl_word[31]);

    assert_busy_tx_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> busy);

endmodule

bind bsnic_top bsnic_chk #(.AW($clog2(WINDOW_BYTES)), .CW(CNT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_sel   (host_sel),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .rx_ready   (rx_ready),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .tx_data    (tx_data),
    .tx_last    (tx_last),
    .ctl_word   (ctl_word),
    .rx_left    (rx_left),
    .tx_cnt     (tx_cnt),
    .busy       (busy)
);

// File: tb/bsnic_top_tb_top.sv
`timescale 1ns/1ps
module bsnic_top_tb_top;

    localparam int          MAX   = 64;
    localparam logic [31:0] INFO  = 32'h0000_0007;
    localparam string       IDSTR = "BYTENIC1";

    logic        clk = 0, rst_n = 0;
    logic        host_sel = 0, host_we = 0;
    logic [5:0]  host_addr = 0;
    logic [31:0] host_wdata = 0, host_rdata;
    logic        rx_valid = 0, rx_first = 0, rx_last = 0, rx_ready;
    logic [7:0]  rx_data = 0;
    logic        tx_valid, tx_last, tx_ready = 0;
    logic [7:0]  tx_data;
    logic        irq;

    int checks = 0, errors = 0;
    int rdy_mode = 2;
    logic loading = 0, early = 0;
    logic [7:0] rxb [0:127];
    logic [7:0] txb [0:127];
    logic [7:0] got [0:127];
    logic       got_last [0:127];
    int got_n = 0;
    logic hold_pend = 0;
    logic [7:0] hold_dat;

    always #2 clk = ~clk;

    bsnic_top #(.INFO_WORD(INFO), .MAX_FRAME(MAX)) dut_i (.*);

    function automatic logic [63:0] exp_id();
        logic [63:0] v = '0;
        for (int k = 0; k < 8; k++) v[8*k +: 8] = IDSTR[k];
        return v;
    endfunction

    function automatic int clamp_len(int n);
        return (n > MAX) ? MAX : n;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic bus_wr(input int a, input logic [31:0] d);
        @(negedge clk);
        host_sel = 1; host_we = 1; host_addr = 6'(a); host_wdata = d;
        @(negedge clk);
        host_sel = 0; host_we = 0;
    endtask

    task automatic bus_rd(input int a, output logic [31:0] d);
        @(negedge clk);
        host_sel = 1; host_we = 0; host_addr = 6'(a);
        #1 d = host_rdata;
        @(negedge clk);
        host_sel = 0;
    endtask

    task automatic rx_byte(input logic [7:0] b, input bit f, input bit l);
        bit ok;
        @(negedge clk);
        rx_valid = 1; rx_data = b; rx_first = f; rx_last = l;
        do begin
            #1 ok = rx_ready;
            if (!ok) @(negedge clk);
        end while (!ok);
        @(negedge clk);
        rx_valid = 0; rx_first = 0; rx_last = 0;
    endtask

    task automatic rx_send(input int len);
        for (int i = 0; i < len; i++) rx_byte(rxb[i], i == 0, i == len - 1);
    endtask

    // transmit sink: random ready, capture, stall check
    always begin
        @(negedge clk);
        #1;
        if (hold_pend && tx_valid)
            chk(tx_data == hold_dat, "R8", "held tx_data", {24'd0, tx_data}, {24'd0, hold_dat});
        hold_pend = 0;
        if (loading && tx_valid) early = 1;
        if (tx_valid && tx_ready) begin
            got[got_n] = tx_data; got_last[got_n] = tx_last; got_n++;
        end else if (tx_valid) begin
            hold_pend = 1; hold_dat = tx_data;
        end
        @(posedge clk);
        #1;
        tx_ready = (rdy_mode == 2) ? 1'b1 : (rdy_mode == 1) ? 1'($urandom % 2) : 1'b0;
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "WD", "watchdog expired", 0, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [63:0] id;
        int len, n;
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst_n = 1;

        // reset state
        bus_rd('h08, d); chk(d == 0, "R2", "busy after reset", d, 0);
        bus_rd('h0c, d); chk(d == 0, "R3", "rx count after reset", d, 0);
        bus_rd('h10, d); chk(d == 0, "R7", "tx count after reset", d, 0);
        bus_rd('h14, d); chk(d == 0, "R12", "intctl after reset", d, 0);
        chk(irq == 0, "R12", "irq after reset", {31'd0, irq}, 0);
        chk(rx_ready == 1, "R5", "rx_ready after reset", {31'd0, rx_ready}, 1);

        // R1 identification and unused space
        id = exp_id();
        bus_rd('h00, d); chk(d == id[31:0], "R1", "id low", d, id[31:0]);
        bus_rd('h04, d); chk(d == id[63:32], "R1", "id high", d, id[63:32]);
        bus_rd('h18, d); chk(d == INFO, "R1", "info", d, INFO);
        bus_wr('h00, 32'hFFFF_FFFF);
        bus_wr('h24, 32'h1234_5678);
        bus_wr('h08, 32'h1);
        bus_rd('h00, d); chk(d == id[31:0], "R1", "id after write", d, id[31:0]);
        bus_rd('h24, d); chk(d == 0, "R1", "unused 0x24", d, 0);
        bus_rd('h3c, d); chk(d == 0, "R1", "unused 0x3c", d, 0);
        bus_rd('h08, d); chk(d == 0, "R1", "busy after write", d, 0);

        // receive frames with random content
        for (int f = 0; f < 5; f++) begin
            len = (f == 0) ? 1 : 1 + int'($urandom % 20);
            for (int i = 0; i < len; i++) rxb[i] = 8'($urandom);
            rx_byte(8'hEE, 0, 0);  // stray byte with no first marker: R3 dropped
            if (len > 1) begin
                rx_byte(rxb[0], 1, 0);
                bus_rd('h08, d); chk(d == 1, "R2", "busy in rx fill", d, 1);
                for (int i = 1; i < len; i++) rx_byte(rxb[i], 0, i == len - 1);
            end else rx_send(1);
            bus_rd('h08, d); chk(d == 0, "R2", "busy after rx", d, 0);
            bus_rd('h0c, d); chk(d == 32'(len), "R3", "rx count loaded", d, 32'(len));
            bus_rd('h14, d); chk(d == 2, "R3", "rx done bit", d, 2);
            chk(irq == 1, "R12", "irq on rx", {31'd0, irq}, 1);
            // blocked offer
            @(negedge clk);
            rx_valid = 1; rx_first = 1; rx_last = 1; rx_data = 8'h5A;
            for (int k = 0; k < 4; k++) begin
                #1 chk(rx_ready == 0, "R5", "rx_ready while done set", {31'd0, rx_ready}, 0);
                @(negedge clk);
            end
            rx_valid = 0; rx_first = 0; rx_last = 0;
            for (int i = 0; i < len; i++) begin
                bus_rd('h1c, d);
                chk(d == {24'd0, rxb[i]}, "R4", "rx byte", d, {24'd0, rxb[i]});
            end
            bus_rd('h0c, d); chk(d == 0, "R4", "rx count drained", d, 0);
            bus_rd('h1c, d); chk(d == 0, "R4", "read past end", d, 0);
            bus_rd('h0c, d); chk(d == 0, "R5", "blocked frame not taken", d, 0);
            bus_wr('h14, 32'h0);
            bus_rd('h14, d); chk(d == 2, "R10", "zero write keeps rx bit", d, 2);
            bus_wr('h14, 32'h2);
            bus_rd('h14, d); chk(d == 0, "R10", "rx bit cleared", d, 0);
            chk(irq == 0, "R12", "irq cleared", {31'd0, irq}, 0);
        end

        // R6 truncation
        len = MAX + 6;
        for (int i = 0; i < len; i++) rxb[i] = 8'(i * 7 + 3);
        rx_send(len);
        bus_rd('h0c, d); chk(d == 32'(MAX), "R6", "truncated count", d, 32'(MAX));
        n = 0;
        for (int i = 0; i < MAX; i++) begin
            bus_rd('h1c, d);
            if (d != {24'd0, rxb[i]}) n++;
        end
        chk(n == 0, "R6", "truncated bytes mismatches", 32'(n), 0);
        bus_rd('h1c, d); chk(d == 0, "R6", "nothing beyond limit", d, 0);
        bus_wr('h14, 32'h2);

        // transmit frames
        for (int f = 0; f < 5; f++) begin
            len = (f == 0) ? 100 : (f == 1) ? 1 : 1 + int'($urandom % 20);
            n = clamp_len(len);
            for (int i = 0; i < n; i++) txb[i] = 8'($urandom);
            got_n = 0; early = 0;
            rdy_mode = (f == 2) ? 0 : 1;
            bus_wr('h10, 0);
            bus_rd('h10, d); chk(d == 0, "R7", "zero count ignored", d, 0);
            loading = 1;
            bus_wr('h10, 32'(len));
            bus_rd('h10, d); chk(d == 32'(n), "R7", "tx count set/clamped", d, 32'(n));
            bus_wr('h10, 32'd3);
            bus_rd('h10, d); chk(d == 32'(n), "R7", "rewrite ignored", d, 32'(n));
            for (int i = 0; i < n - 1; i++) bus_wr('h20, {24'hABCDEF, txb[i]});
            @(negedge clk); #1;
            loading = 0;
            chk(early == 0 && tx_valid == 0, "R7", "no output before full count", {31'd0, early}, 0);
            bus_wr('h20, {24'd0, txb[n - 1]});
            if (f == 2) begin
                bus_rd('h08, d); chk(d == 1, "R2", "busy while sending", d, 1);
                bus_rd('h14, d); chk(d == 0, "R9", "no done while stalled", d, 0);
                rdy_mode = 1;
            end
            for (int w = 0; w < 2000 && got_n < n; w++) @(negedge clk);
            repeat (2) @(negedge clk);
            chk(got_n == n, "R8", "tx byte count", 32'(got_n), 32'(n));
            for (int i = 0; i < n; i++) begin
                chk(got[i] == txb[i], "R8", "tx byte", {24'd0, got[i]}, {24'd0, txb[i]});
                chk(got_last[i] == (i == n - 1), "R8", "tx last marker",
                    {31'd0, got_last[i]}, {31'd0, 1'(i == n - 1)});
            end
            bus_rd('h10, d); chk(d == 0, "R9", "tx count cleared", d, 0);
            bus_rd('h14, d); chk(d == 1, "R9", "tx done bit", d, 1);
            chk(irq == 1, "R12", "irq on tx", {31'd0, irq}, 1);
            bus_wr('h14, 32'h1);
            bus_rd('h14, d); chk(d == 0, "R10", "tx bit cleared", d, 0);
        end
        rdy_mode = 2;

        // R10 selective clear with both set
        rxb[0] = 8'h11; rx_send(1);
        bus_wr('h10, 1); bus_wr('h20, 32'h22);
        repeat (4) @(negedge clk);
        bus_rd('h14, d); chk(d == 3, "R10", "both bits set", d, 3);
        bus_wr('h14, 32'h1);
        bus_rd('h14, d); chk(d == 2, "R10", "only tx cleared", d, 2);
        bus_rd('h1c, d);
        bus_wr('h14, 32'h2);

        // R11 test bit
        bus_wr('h14, 32'h8000_0000);
        @(negedge clk); #1;
        chk(irq == 1, "R11", "irq from test bit", {31'd0, irq}, 1);
        bus_rd('h14, d); chk(d == 32'h8000_0000, "R11", "test bit read", d, 32'h8000_0000);
        bus_rd('h14, d); chk(d == 0, "R11", "test bit cleared by read", d, 0);
        chk(irq == 0, "R12", "irq low after test clear", {31'd0, irq}, 0);
        bus_wr('h14, 32'h8000_0000);
        bus_wr('h14, 32'h0);
        @(negedge clk); #1;
        chk(irq == 0, "R11", "zero write clears test", {31'd0, irq}, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule